// File: doc/BRIEF.md
# March-Test Memory Self-Test Controller

This block is a built-in self-test engine for a single-port synchronous RAM of 256 words by 16 bits. A start strobe launches one of three March algorithms: March C-, March SR or March B. The engine then drives the RAM's address, write data, write enable and read strobe by itself, one operation per clock. Each March element applies all of its operations to one cell before the address moves on. The address climbs from the lowest cell to the highest or falls the other way, depending on the element.

Every read is compared with the value the algorithm expects, one cycle after it is issued. The address of the first read that differs is kept, together with the data actually read. When the last operation has been checked, a one-cycle done pulse marks the end of the run. The pass flag and the diagnosis values then stay put until the next accepted start. A RAM is treated as fault-free only when it passes all three algorithms, so a user runs the controller three times, once with each select code.

Top module: `march_bist`

## Requirements
- R1: test_sel 0 selects March C- (2560 operations), 1 selects March SR (3584 operations) and 2 selects March B (4352 operations). If start is sampled at clock edge k, the operations issue one per cycle at edges k+1 to k+N, and done is high in the cycle that follows edge k+N+1.
- R2: The element sequences are as follows, where U means addresses 0 up to 255 and D means 255 down to 0. C- is U(w0) U(r0,w1) U(r1,w0) D(r0,w1) D(r1,w0) U(r0). SR is D(w0) U(r0,w1,r1,w0) U(r0,r0) U(w1) D(r1,w0,r0,w1) D(r1,r1). B is U(w0) U(r0,w1,r1,w0,r0,w1) U(r1,w0,w1) D(r1,w0,w1,w0) D(r0,w1,w0). All operations of an element are applied to one address before the address moves on.
- R3: A write of 0 drives mem_wdata 0x0000 and a write of 1 drives 0xFFFF, with mem_we high and mem_re low. A read raises mem_re with mem_we low. When the block is not busy, both strobes are low.
- R4: mem_rdata is compared, one cycle after the read strobe, with 0x0000 (read 0) or 0xFFFF (read 1). After done, pass is 1 exactly when no compare differed.
- R5: fail_addr and fail_data take the address and the read data of the first differing read. Later differing reads leave them unchanged.
- R6: done is high for exactly one cycle per run, and the run ends with done whether or not a read failed.
- R7: A start that arrives while busy is high, whatever test_sel is at that time, does not change the operation stream or the results of the run in progress.
- R8: pass, fail_addr and fail_data keep their values after done until the next accepted start. They read 0 in the first cycle after that start.
- R9: After reset, busy, done, pass, mem_we, mem_re and fail_addr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch strobe, accepted only when busy is low |
| test_sel | input | 2 | Algorithm code: 0 C-, 1 SR, 2 B (3 behaves as 0) |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after mem_re |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read strobe |
| busy | output | 1 | Run in progress, including the last compare |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run had no mismatch |
| fail_addr | output | ADDR_W | Address of the first mismatching read |
| fail_data | output | DATA_W | Data returned by the first mismatching read |

## Verification
The bench builds the block with its default values, ADDR_W 8 and DATA_W 16, so every run covers the full 256-word array. That brings both address ends within reach, along with each switch between ascending and descending elements. A run of a few thousand cycles per algorithm lets the bench compare every single RAM operation against its own walk of the three algorithms. This also leaves room for random stuck-bit faults at one or two addresses, which exercise first-fail capture across elements.

// File: rtl/march_pkg.sv
// Shared definitions for the March self-test engine: operation codes,
// element descriptor and the algorithm tables.
// Assumes at most six operations per element and six elements per test.
package march_pkg;
    localparam int MAX_OPS = 6;

    // Operation code: bit 1 = read, bit 0 = data value (0 or all ones).
    typedef logic [1:0] mop_t;
    localparam mop_t W0 = 2'b00;
    localparam mop_t W1 = 2'b01;
    localparam mop_t R0 = 2'b10;
    localparam mop_t R1 = 2'b11;

    typedef struct packed {
        logic                     down;
        logic [2:0]               nops;
        mop_t [MAX_OPS-1:0]       ops;   // ops[0] runs first
    } elem_t;

    function automatic elem_t mk(logic dn, logic [2:0] n, mop_t o0, mop_t o1,
                                 mop_t o2, mop_t o3, mop_t o4, mop_t o5);
        elem_t e;
        e.down = dn;
        e.nops = n;
        e.ops  = {o5, o4, o3, o2, o1, o0};
        return e;
    endfunction

    // Index of the final element for an algorithm code.
    function automatic logic [2:0] last_elem(logic [1:0] alg);
        return (alg == 2'd2) ? 3'd4 : 3'd5;
    endfunction

    // Element descriptor for algorithm alg, position idx.
    function automatic elem_t elem_of(logic [1:0] alg, logic [2:0] idx);
        elem_t e;
        e = mk(1'b0, 3'd1, W0, W0, W0, W0, W0, W0);
        case (alg)
            2'd1: case (idx)
                3'd0: e = mk(1'b1, 3'd1, W0, W0, W0, W0, W0, W0);
                3'd1: e = mk(1'b0, 3'd4, R0, W1, R1, W0, W0, W0);
                3'd2: e = mk(1'b0, 3'd2, R0, R0, W0, W0, W0, W0);
                3'd3: e = mk(1'b0, 3'd1, W1, W0, W0, W0, W0, W0);
                3'd4: e = mk(1'b1, 3'd4, R1, W0, R0, W1, W0, W0);
                default: e = mk(1'b1, 3'd2, R1, R1, W0, W0, W0, W0);
            endcase
            2'd2: case (idx)
                3'd0: e = mk(1'b0, 3'd1, W0, W0, W0, W0, W0, W0);
                3'd1: e = mk(1'b0, 3'd6, R0, W1, R1, W0, R0, W1);
                3'd2: e = mk(1'b0, 3'd3, R1, W0, W1, W0, W0, W0);
                3'd3: e = mk(1'b1, 3'd4, R1, W0, W1, W0, W0, W0);
                default: e = mk(1'b1, 3'd3, R0, W1, W0, W0, W0, W0);
            endcase
            default: case (idx)
                3'd0: e = mk(1'b0, 3'd1, W0, W0, W0, W0, W0, W0);
                3'd1: e = mk(1'b0, 3'd2, R0, W1, W0, W0, W0, W0);
                3'd2: e = mk(1'b0, 3'd2, R1, W0, W0, W0, W0, W0);
                3'd3: e = mk(1'b1, 3'd2, R0, W1, W0, W0, W0, W0);
                3'd4: e = mk(1'b1, 3'd2, R1, W0, W0, W0, W0, W0);
                default: e = mk(1'b0, 3'd1, R0, W0, W0, W0, W0, W0);
            endcase
        endcase
        return e;
    endfunction
endpackage

// File: rtl/march_seq.sv
// Operation sequencer: walks elements, addresses and operations of the
// selected algorithm, one operation per cycle while running.
// Assumes start_i is only raised when the caller is idle.
module march_seq
    import march_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        alg_i,
    output logic              run_o,
    output logic [ADDR_W-1:0] addr_o,
    output mop_t              op_o,
    output logic              last_o
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    logic              run;
    logic [1:0]        alg_q;
    logic [2:0]        eidx;
    logic [2:0]        oidx;
    logic [ADDR_W-1:0] addr;
    elem_t             cur, nxt, first;
    logic              op_end, addr_end, elem_end;

    // Decode the current, next and launch elements and the end conditions.
    always_comb begin
        cur      = elem_of(alg_q, eidx);
        nxt      = elem_of(alg_q, 3'(eidx + 3'd1));
        first    = elem_of(alg_i, 3'd0);
        op_end   = (oidx == 3'(cur.nops - 3'd1));
        addr_end = cur.down ? (addr == '0) : (addr == TOP_ADDR);
        elem_end = (eidx == last_elem(alg_q));
    end

    // Advance operation, then address, then element; stop after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            alg_q <= 2'd0;
            eidx  <= 3'd0;
            oidx  <= 3'd0;
            addr  <= '0;
        end else if (!run) begin
            if (start_i) begin
                run   <= 1'b1;
                alg_q <= alg_i;
                eidx  <= 3'd0;
                oidx  <= 3'd0;
                addr  <= first.down ? TOP_ADDR : '0;
            end
        end else if (!op_end) begin
            oidx <= oidx + 3'd1;
        end else begin
            oidx <= 3'd0;
            if (!addr_end) begin
                addr <= cur.down ? addr - 1'b1 : addr + 1'b1;
            end else if (elem_end) begin
                run <= 1'b0;
            end else begin
                eidx <= eidx + 3'd1;
                addr <= nxt.down ? TOP_ADDR : '0;
            end
        end
    end

    assign run_o  = run;
    assign addr_o = addr;
    assign op_o   = cur.ops[oidx];
    assign last_o = run & op_end & addr_end & elem_end;

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && oidx != 3'd0) |-> addr == $past(addr));

    // R7
    alg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> alg_q == $past(alg_q));
endmodule

// File: rtl/march_chk.sv
// Read checker: holds each read's expected value and address for one
// cycle, compares with the returned data, records the first mismatch and
// raises the end-of-run pulse. Assumes one cycle of RAM read latency.
module march_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rd_issue,
    input  logic              rd_exp,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              last_issue,
    input  logic [DATA_W-1:0] rdata,
    output logic              fin_o,
    output logic              done_o,
    output logic              pass_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [DATA_W-1:0] fail_data_o
);
    logic              pv, pexp, plast;
    logic [ADDR_W-1:0] paddr;
    logic              failed, have;
    logic              mismatch;

    // Compare the returned word against the held expected value.
    assign mismatch = pv && (rdata != {DATA_W{pexp}});

    // Pipeline register carrying the read's expectation into the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv    <= 1'b0;
            pexp  <= 1'b0;
            paddr <= '0;
            plast <= 1'b0;
        end else begin
            pv    <= rd_issue;
            pexp  <= rd_exp;
            paddr <= rd_addr;
            plast <= last_issue;
        end
    end

    // End-of-run pulse, one cycle after the final operation's compare slot.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= plast;
    end

    // Result registers: cleared on launch, first mismatch captured once.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            failed      <= 1'b0;
            have        <= 1'b0;
            fail_addr_o <= '0;
            fail_data_o <= '0;
        end else begin
            if (mismatch && !failed) begin
                failed      <= 1'b1;
                fail_addr_o <= paddr;
                fail_data_o <= rdata;
            end
            if (plast) have <= 1'b1;
        end
    end

    assign fin_o  = plast;
    assign pass_o = have & ~failed;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    first_fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (failed && !clear) |=> ($stable(fail_addr_o) && $stable(fail_data_o)));

    // R4
    mismatch_blocks_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && !clear) |=> !pass_o);
endmodule

// File: rtl/march_bist.sv
// Top of the March self-test controller: gates the launch strobe, maps
// sequencer operations onto the RAM strobes and hosts the read checker.
// Assumes a single-port RAM with registered read data (one cycle latency).
module march_bist
    import march_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        test_sel,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_data
);
    logic              accept, run, last, fin;
    logic [ADDR_W-1:0] addr;
    mop_t              op;

    // Launch only while idle; a strobe during a run is dropped.
    assign accept = start & ~busy;
    assign busy   = run | fin;

    march_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (accept),
        .alg_i   (test_sel),
        .run_o   (run),
        .addr_o  (addr),
        .op_o    (op),
        .last_o  (last)
    );

    // RAM-side strobes and data derived from the current operation.
    assign mem_addr  = addr;
    assign mem_we    = run & ~op[1];
    assign mem_re    = run & op[1];
    assign mem_wdata = {DATA_W{op[0]}};

    march_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (accept),
        .rd_issue    (mem_re),
        .rd_exp      (op[0]),
        .rd_addr     (addr),
        .last_issue  (last),
        .rdata       (mem_rdata),
        .fin_o       (fin),
        .done_o      (done),
        .pass_o      (pass),
        .fail_addr_o (fail_addr),
        .fail_data_o (fail_data)
    );

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    // R3
    wdata_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == '0 || mem_wdata == '1));
endmodule

// File: tb/tb_march_bist.sv
// Self-checking bench: RAM model with up to two read-path stuck-bit faults,
// a bench-side walk of every algorithm checking each operation and result.
module tb_march_bist;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  test_sel = 2'd0;
    logic [15:0] mem_rdata;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we, mem_re, busy, done, pass;
    logic [7:0]  fail_addr;
    logic [15:0] fail_data;

    int total = 0;
    int fails = 0;

    // Fault slots: address, stuck mask, stuck value.
    logic        f_en [2];
    logic [7:0]  f_adr [2];
    logic [15:0] f_msk [2];
    logic [15:0] f_val [2];
    logic [15:0] mem [256];

    always #4 clk = ~clk;

    march_bist dut (
        .clk(clk), .rst_n(rst_n), .start(start), .test_sel(test_sel),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .busy(busy), .done(done),
        .pass(pass), .fail_addr(fail_addr), .fail_data(fail_data)
    );

    function automatic logic [15:0] ram_view(logic [7:0] a, logic [15:0] v);
        logic [15:0] r = v;
        for (int i = 0; i < 2; i++)
            if (f_en[i] && f_adr[i] == a) r = (r & ~f_msk[i]) | (f_val[i] & f_msk[i]);
        return r;
    endfunction

    // RAM model: registered read, write on the clock edge.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= ram_view(mem_addr, mem[mem_addr]);
    end

    function automatic string elem_str(int alg, int e);
        string t[3][6] = '{
            '{"U:w0", "U:r0w1", "U:r1w0", "D:r0w1", "D:r1w0", "U:r0"},
            '{"D:w0", "U:r0w1r1w0", "U:r0r0", "U:w1", "D:r1w0r0w1", "D:r1r1"},
            '{"U:w0", "U:r0w1r1w0r0w1", "U:r1w0w1", "D:r1w0w1w0", "D:r0w1w0", ""}};
        return t[alg][e];
    endfunction

    function automatic int total_ops(int alg);
        return (alg == 0) ? 2560 : (alg == 1) ? 3584 : 4352;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] got, logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
        end
    endtask

    task automatic set_faults(logic e0, logic [7:0] a0, logic [15:0] m0, logic [15:0] v0,
                              logic e1, logic [7:0] a1, logic [15:0] m1, logic [15:0] v1);
        f_en[0] = e0; f_adr[0] = a0; f_msk[0] = m0; f_val[0] = v0;
        f_en[1] = e1; f_adr[1] = a1; f_msk[1] = m1; f_val[1] = v1;
    endtask

    // One full run with operation-by-operation checking; poke_at >= 2
    // raises start mid-run with another select code.
    task automatic run(int alg, int poke_at);
        int          n = 0;
        int          errs = 0;
        logic [31:0] e_got = 0, e_exp = 0;
        logic        x_fail = 0;
        logic [7:0]  x_addr = 0;
        logic [15:0] x_data = 0;
        logic        clr_pass = 0;
        logic [7:0]  clr_addr = 0;
        @(negedge clk);
        start = 1'b1;
        test_sel = 2'(alg);
        for (int e = 0; e < ((alg == 2) ? 5 : 6); e++) begin
            string s = elem_str(alg, e);
            bit dn = (s[0] == "D");
            int nop = (s.len() - 2) / 2;
            for (int k = 0; k < 256; k++) begin
                logic [7:0] a = dn ? 8'(255 - k) : 8'(k);
                for (int o = 0; o < nop; o++) begin
                    bit rd = (s[2 + 2*o] == "r");
                    bit bv = (s[3 + 2*o] == "1");
                    @(negedge clk);
                    if (n == 0) begin
                        start = 1'b0;
                        clr_pass = pass;
                        clr_addr = fail_addr;
                    end
                    if (poke_at >= 2 && n == poke_at) begin
                        start = 1'b1;
                        test_sel = 2'((alg + 1) % 3);
                    end else if (poke_at >= 2 && n == poke_at + 1) begin
                        start = 1'b0;
                    end
                    if (mem_addr != a || mem_we != !rd || mem_re != rd ||
                        (!rd && mem_wdata != {16{bv}})) begin
                        if (errs == 0) begin
                            e_got = {mem_re, mem_we, 6'd0, mem_addr, mem_wdata};
                            e_exp = {rd, !rd, 6'd0, a, {16{bv}}};
                        end
                        errs++;
                    end
                    if (rd && !x_fail && ram_view(a, {16{bv}}) != {16{bv}}) begin
                        x_fail = 1'b1;
                        x_addr = a;
                        x_data = ram_view(a, {16{bv}});
                    end
                    n++;
                end
            end
        end
        chk(errs == 0, (poke_at >= 2) ? "R7" : "R2", "R2/R3 op stream {re,we,addr,wdata}", e_got, e_exp);
        chk(n == total_ops(alg), "R1", "op count", n, total_ops(alg));
        chk(clr_pass == 0 && clr_addr == 0, "R8", "results cleared on start", {clr_pass, clr_addr}, 0);
        @(negedge clk);
        chk(!done && busy, "R1", "done early / busy", {done, busy}, 2'b01);
        @(negedge clk);
        chk(done, "R1", "done after last compare", done, 1);
        chk(pass == !x_fail, "R4", "pass", pass, !x_fail);
        chk(fail_addr == x_addr && fail_data == x_data, "R5", "first fail {addr,data}",
            {fail_addr, fail_data}, {x_addr, x_data});
        @(negedge clk);
        chk(!done && !busy, "R6", "done single cycle / idle", {done, busy}, 0);
        repeat (3) @(negedge clk);
        chk(pass == !x_fail && fail_addr == x_addr && fail_data == x_data, "R8",
            "results held {pass,addr,data}", {pass, fail_addr, fail_data}, {!x_fail, x_addr, x_data});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: run did not finish, got hung exp done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        set_faults(0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(!busy && !done && !pass && !mem_we && !mem_re && fail_addr == 0, "R9",
            "reset state", {busy, done, pass, mem_we, mem_re, fail_addr}, 0);
        // R1 R4 clean runs of every algorithm
        for (int a = 0; a < 3; a++) run(a, 0);
        // R5 stuck-at-1 at 0xAA in each algorithm
        set_faults(1, 8'hAA, 16'h0100, 16'hFFFF, 0, 0, 0, 0);
        for (int a = 0; a < 3; a++) run(a, 0);
        // R5 two faults: later mismatches must not overwrite the first
        set_faults(1, 8'h10, 16'h0008, 16'hFFFF, 1, 8'h05, 16'h0001, 16'h0000);
        run(0, 0);
        // R7 start during a run with another code
        set_faults(1, 8'h00, 16'h8000, 16'h0000, 0, 0, 0, 0);
        run(1, 37);
        // Random faults and algorithms
        for (int i = 0; i < 12; i++) begin
            int alg = $urandom_range(2, 0);
            logic [15:0] m0 = 16'(1 << $urandom_range(15, 0));
            logic [15:0] m1 = 16'(1 << $urandom_range(15, 0));
            set_faults(1'($urandom_range(1, 0)), 8'($urandom_range(255, 0)), m0,
                       $urandom_range(1, 0) ? 16'hFFFF : 16'h0000,
                       1'($urandom_range(1, 0)), 8'($urandom_range(255, 0)), m1,
                       $urandom_range(1, 0) ? 16'hFFFF : 16'h0000);
            run(alg, (i % 3 == 0) ? int'($urandom_range(2000, 2)) : 0);
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule